// File: doc/BRIEF.md
# Multi-Input Clock Frequency Offset Monitor

This block judges how far each of five input clocks has drifted from a chosen reference and reports the drift as a parts-per-million figure. Every input is brought into the block clock domain and reduced to one-cycle rising-edge strobes. For each input, a gate counter opens on one edge and counts reference ticks until a fixed number of further edges have arrived. The shortfall or excess against the nominal tick count, scaled to ppm, becomes that input's stored measurement. The reference tick comes from one of two strobes: a master tick or a recovered system tick. A single control input chooses between them.

The ppm resolution step is programmable, and the same step serves two purposes. It sets the hard alarm limit, which is (threshold code + 1) × step. It also scales the 8-bit signed readback value. A global enable can silence every alarm. An input with an active alarm is also flagged as unfit for reference selection. A host reads one channel at a time: it sets a channel-select field and pulses a capture strobe. The result is latched, so it stays still while the host reads it.

Top module: `fdm_freq_monitor`

## Requirements
- R1: For each input, the block counts reference ticks from one rising edge through the GATE_EDGES-th following edge. The count covers the cycles after the opening edge, up to and including the closing edge. The stored offset is (NOM_REF_CNT − count) × PPM_NUM / NOM_REF_CNT, truncated toward zero. It is positive when the input runs faster than nominal. A new gate opens on the closing edge of the previous one.
- R2: `ref_sel` = 0 counts `mst_ref_tick` as the reference; `ref_sel` = 1 counts `sys_ref_tick`.
- R3: The readback value is the selected channel's offset divided by the step, truncated toward zero. It is an 8-bit two's complement number that saturates at +127 and −128 instead of wrapping. The step equals `step_code`, and a code of 0 acts as 1.
- R4: The alarm limit in ppm is (`thr_code` + 1) × step. With `hard_en` = 1, bit i of `hard_alarm` is 1 while the stored offset magnitude of input i is strictly above the limit. It returns to 0 once the magnitude is at or below the limit. An offset exactly at the limit does not alarm. The alarm follows the stored measurement and configuration with one cycle of latency.
- R5: With `hard_en` = 0, every bit of `hard_alarm` is 0, whatever the offsets.
- R6: Bit i of `disq` equals bit i of `hard_alarm`, and bit i belongs to input i.
- R7: An input that completes no gate within 2 × NOM_REF_CNT reference ticks is marked dead. A dead input reads back as −128 and counts as above any limit. It recovers when its next full gate closes.
- R8: A capture with `rd_sel` of 5 or higher latches 0.
- R9: A high `rd_strobe` at a clock edge latches the value for channel `rd_sel` (0 to 4), and `rd_value` shows it from the next cycle. Without a strobe, `rd_value` holds, even when `rd_sel` or the measurements change.
- R10: After reset, every stored offset is 0, no input is dead, and `hard_alarm`, `disq` and `rd_value` are 0.
- R11: A capture in the same cycle that a gate closes latches the previously stored offset. The new one becomes visible to the next capture, so a read never shows a half-updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_ref_tick | input | 1 | Master reference tick strobe, one clk cycle wide |
| sys_ref_tick | input | 1 | Recovered system reference tick strobe, one clk cycle wide |
| ref_sel | input | 1 | Reference choice: 0 master, 1 system |
| in_clk | input | N_CH | Raw monitored input clocks, bit i is input i |
| hard_en | input | 1 | Global hard alarm enable |
| thr_code | input | 4 | Alarm limit multiplier minus one |
| step_code | input | 4 | ppm resolution step (0 treated as 1) |
| rd_sel | input | 4 | Channel to capture |
| rd_strobe | input | 1 | Capture request |
| rd_value | output | 8 | Latched signed offset in steps |
| hard_alarm | output | N_CH | Per-input hard alarm |
| disq | output | N_CH | Per-input disqualify flag |

## Verification
A host capture can fall in the same cycle in which the selected input's gate closes and its stored measurement is replaced. The bench provokes this by holding the capture strobe high on every cycle for three gate periods after changing one input's period. Some capture is then certain to meet the update cycle, and the only gate that sees both periods is one mixed gate. The bench accepts the run only if every latched value lies between the old and new offsets, never moves backward, changes at most twice, and ends at the new offset.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

    localparam int SEL_W   = 4;
    localparam int CFG_W   = 4;
    localparam int VAL_W   = 8;
    localparam int PPM_W   = 32;
    localparam int VAL_MAX = (1 << (VAL_W - 1)) - 1;

    typedef logic signed [VAL_W-1:0] fval_t;
    typedef logic signed [PPM_W-1:0] ppm_t;

    typedef enum logic [0:0] {
        GATE_IDLE = 1'b0,
        GATE_RUN  = 1'b1
    } gate_st_e;

    typedef struct packed {
        logic dead;
        ppm_t ppm;
    } meas_t;

    // Resolution step; a zero code behaves as a step of one.
    function automatic logic [CFG_W:0] step_of(input logic [CFG_W-1:0] code);
        logic [CFG_W:0] s;
        s = (code == '0) ? (CFG_W + 1)'(1) : {1'b0, code};
        return s;
    endfunction

    // Clamp a wide signed offset into the readback range.
    function automatic fval_t sat_val(input ppm_t x);
        ppm_t hi;
        ppm_t lo;
        hi = PPM_W'(VAL_MAX);
        lo = -hi - 1;
        if (x > hi) return fval_t'(VAL_MAX);
        if (x < lo) return fval_t'(-VAL_MAX - 1);
        return fval_t'(x[VAL_W-1:0]);
    endfunction

    function automatic ppm_t abs_ppm(input ppm_t x);
        return (x < 0) ? -x : x;
    endfunction

endpackage

// File: rtl/fdm_edge_sync.sv
module fdm_edge_sync #(
    parameter int N_CH = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] raw,
    output logic [N_CH-1:0] stb
);
    logic [N_CH-1:0] meta_q;
    logic [N_CH-1:0] sync_q;
    logic [N_CH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign stb = sync_q & ~last_q;

endmodule

// File: rtl/fdm_gate_counter.sv
module fdm_gate_counter
    import fdm_pkg::*;
#(
    parameter int GATE_EDGES  = 8000,
    parameter int NOM_REF_CNT = 1000000,
    parameter int PPM_NUM     = 1000000
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_tick,
    input  logic  edge_stb,
    output meas_t meas
);
    localparam int TIMEOUT = 2 * NOM_REF_CNT;
    localparam int CNT_W   = $clog2(TIMEOUT + 1);
    localparam int EDGE_W  = $clog2(GATE_EDGES + 1);

    gate_st_e          st_q;
    logic [CNT_W-1:0]  ref_q;
    logic [EDGE_W-1:0] edg_q;
    meas_t             meas_q;
    logic [CNT_W-1:0]  ref_now;
    logic              done;
    logic              tmo;

    function automatic ppm_t to_ppm(input logic [CNT_W-1:0] cnt);
        longint d;
        d = longint'(NOM_REF_CNT) - longint'(cnt);
        return PPM_W'((d * longint'(PPM_NUM)) / longint'(NOM_REF_CNT));
    endfunction

    always_comb begin
        ref_now = ref_q + CNT_W'(ref_tick);
        done    = (st_q == GATE_RUN) && edge_stb && (edg_q == EDGE_W'(GATE_EDGES - 1));
        tmo     = !done && (ref_now >= CNT_W'(TIMEOUT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= GATE_IDLE;
            ref_q  <= '0;
            edg_q  <= '0;
            meas_q <= '0;
        end else if (done) begin
            meas_q.dead <= 1'b0;
            meas_q.ppm  <= to_ppm(ref_now);
            ref_q       <= '0;
            edg_q       <= '0;
        end else if (tmo) begin
            meas_q.dead <= 1'b1;
            meas_q.ppm  <= '0;
            st_q        <= GATE_IDLE;
            ref_q       <= '0;
            edg_q       <= '0;
        end else if (edge_stb) begin
            if (st_q == GATE_IDLE) begin
                st_q  <= GATE_RUN;
                ref_q <= '0;
                edg_q <= '0;
            end else begin
                edg_q <= edg_q + EDGE_W'(1);
                ref_q <= ref_now;
            end
        end else begin
            ref_q <= ref_now;
        end
    end

    assign meas = meas_q;

    AST_MEAS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(done || tmo) |=> $stable(meas_q)); // R1
    AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
        ref_q < CNT_W'(TIMEOUT)); // R7

endmodule

// File: rtl/fdm_alarm.sv
module fdm_alarm
    import fdm_pkg::*;
#(
    parameter int N_CH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  meas_t            meas [N_CH],
    input  logic             hard_en,
    input  logic [CFG_W-1:0] thr_code,
    input  logic [CFG_W-1:0] step_code,
    output logic [N_CH-1:0]  alarm
);
    localparam int TH_W = 2 * (CFG_W + 1);

    logic [CFG_W:0]  step;
    logic [CFG_W:0]  mult;
    logic [TH_W-1:0] lim;
    ppm_t            lim_w;
    logic [N_CH-1:0] over;
    logic [N_CH-1:0] alarm_q;

    always_comb begin
        step  = step_of(step_code);
        mult  = {1'b0, thr_code} + (CFG_W + 1)'(1);
        lim   = TH_W'(mult) * TH_W'(step);
        lim_w = PPM_W'(lim);
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_cmp
        ppm_t mag;
        assign mag     = abs_ppm(meas[i].ppm);
        assign over[i] = meas[i].dead || (mag > lim_w);

        AST_DEAD_ALARMS: assert property (@(posedge clk) disable iff (rst)
            hard_en && meas[i].dead |=> alarm_q[i]); // R7
        AST_AT_LIMIT_QUIET: assert property (@(posedge clk) disable iff (rst)
            hard_en && !meas[i].dead && (mag == lim_w) |=> !alarm_q[i]); // R4
    end

    always_ff @(posedge clk) begin
        if (rst) alarm_q <= '0;
        else     alarm_q <= hard_en ? over : '0;
    end

    assign alarm = alarm_q;

    AST_EN_GATES_ALARM: assert property (@(posedge clk) disable iff (rst)
        (|alarm_q) |-> $past(hard_en)); // R5

endmodule

// File: rtl/fdm_readback.sv
module fdm_readback
    import fdm_pkg::*;
#(
    parameter int N_CH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  meas_t            meas [N_CH],
    input  logic [SEL_W-1:0] rd_sel,
    input  logic             rd_strobe,
    input  logic [CFG_W-1:0] step_code,
    output logic [VAL_W-1:0] rd_value
);
    meas_t pick;
    logic  hit;
    ppm_t  divisor;
    ppm_t  quo;
    fval_t nxt;
    fval_t rd_q;

    always_comb begin
        pick = '0;
        hit  = 1'b0;
        for (int i = 0; i < N_CH; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                pick = meas[i];
                hit  = 1'b1;
            end
        end
        divisor = $signed(PPM_W'(step_of(step_code)));
        quo     = pick.ppm / divisor;
        if (!hit)           nxt = '0;
        else if (pick.dead) nxt = fval_t'(-VAL_MAX - 1);
        else                nxt = sat_val(quo);
    end

    always_ff @(posedge clk) begin
        if (rst)            rd_q <= '0;
        else if (rd_strobe) rd_q <= nxt;
    end

    assign rd_value = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_q)); // R9
    AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_strobe && (rd_sel >= SEL_W'(N_CH)) |=> (rd_q == '0)); // R8

endmodule

// File: rtl/fdm_freq_monitor.sv
module fdm_freq_monitor
    import fdm_pkg::*;
#(
    parameter int N_CH        = 5,
    parameter int GATE_EDGES  = 8000,
    parameter int NOM_REF_CNT = 1000000,
    parameter int PPM_NUM     = 1000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mst_ref_tick,
    input  logic             sys_ref_tick,
    input  logic             ref_sel,
    input  logic [N_CH-1:0]  in_clk,
    input  logic             hard_en,
    input  logic [3:0]       thr_code,
    input  logic [3:0]       step_code,
    input  logic [3:0]       rd_sel,
    input  logic             rd_strobe,
    output logic [7:0]       rd_value,
    output logic [N_CH-1:0]  hard_alarm,
    output logic [N_CH-1:0]  disq
);
    logic            ref_tick;
    logic [N_CH-1:0] edge_stb;
    meas_t           meas [N_CH];

    assign ref_tick = ref_sel ? sys_ref_tick : mst_ref_tick;

    fdm_edge_sync #(.N_CH(N_CH)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (in_clk),
        .stb (edge_stb)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_gate
        fdm_gate_counter #(
            .GATE_EDGES  (GATE_EDGES),
            .NOM_REF_CNT (NOM_REF_CNT),
            .PPM_NUM     (PPM_NUM)
        ) u_gate (
            .clk      (clk),
            .rst      (rst),
            .ref_tick (ref_tick),
            .edge_stb (edge_stb[i]),
            .meas     (meas[i])
        );
    end

    fdm_alarm #(.N_CH(N_CH)) u_alarm (
        .clk       (clk),
        .rst       (rst),
        .meas      (meas),
        .hard_en   (hard_en),
        .thr_code  (thr_code),
        .step_code (step_code),
        .alarm     (hard_alarm)
    );

    fdm_readback #(.N_CH(N_CH)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .meas      (meas),
        .rd_sel    (rd_sel),
        .rd_strobe (rd_strobe),
        .step_code (step_code),
        .rd_value  (rd_value)
    );

    assign disq = hard_alarm;

endmodule

// File: tb/fdm_freq_monitor_tb_top.sv
module fdm_freq_monitor_tb_top;

    localparam int NC = 5;

    typedef struct packed {
        logic [4:0][9:0] per;
        logic [3:0]      stp;
        logic [3:0]      thr;
        logic            en;
        logic            rs;
    } vec_t;

    // per listed as {ch4, ch3, ch2, ch1, ch0}; 0 means the input is held still
    localparam vec_t VECS [8] = '{
        '{per:{10'd253,10'd247,10'd252,10'd248,10'd250}, stp:4'd1,  thr:4'd7,  en:1'b1, rs:1'b0},
        '{per:{10'd250,10'd0,  10'd290,10'd282,10'd218}, stp:4'd1,  thr:4'd7,  en:1'b1, rs:1'b0},
        '{per:{10'd250,10'd0,  10'd290,10'd282,10'd218}, stp:4'd1,  thr:4'd7,  en:1'b0, rs:1'b0},
        '{per:{10'd245,10'd250,10'd260,10'd240,10'd247}, stp:4'd3,  thr:4'd3,  en:1'b1, rs:1'b0},
        '{per:{10'd250,10'd255,10'd254,10'd246,10'd245}, stp:4'd0,  thr:4'd15, en:1'b1, rs:1'b0},
        '{per:{10'd250,10'd250,10'd250,10'd250,10'd250}, stp:4'd15, thr:4'd15, en:1'b1, rs:1'b1},
        '{per:{10'd226,10'd249,10'd254,10'd246,10'd250}, stp:4'd15, thr:4'd0,  en:1'b1, rs:1'b0},
        '{per:{10'd250,10'd250,10'd250,10'd250,10'd250}, stp:4'd1,  thr:4'd7,  en:1'b1, rs:1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mst_tick = 1'b1;
    logic          sys_tick = 1'b0;
    logic          ref_sel = 1'b0;
    logic [NC-1:0] in_clk;
    logic          hard_en = 1'b0;
    logic [3:0]    thr_code = 4'd0;
    logic [3:0]    step_code = 4'd1;
    logic [3:0]    rd_sel = 4'd0;
    logic          rd_strobe = 1'b0;
    logic [7:0]    rd_value;
    logic [NC-1:0] hard_alarm;
    logic [NC-1:0] disq;
    logic [9:0]    per_cur [NC];

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    fdm_freq_monitor #(
        .N_CH(NC), .GATE_EDGES(4), .NOM_REF_CNT(1000), .PPM_NUM(1000)
    ) dut_i (
        .clk(clk), .rst(rst), .mst_ref_tick(mst_tick), .sys_ref_tick(sys_tick),
        .ref_sel(ref_sel), .in_clk(in_clk), .hard_en(hard_en), .thr_code(thr_code),
        .step_code(step_code), .rd_sel(rd_sel), .rd_strobe(rd_strobe),
        .rd_value(rd_value), .hard_alarm(hard_alarm), .disq(disq)
    );

    initial begin
        for (int c = 0; c < NC; c++) per_cur[c] = 10'd250;
        forever begin
            @(negedge clk);
            sys_tick = ~sys_tick;
        end
    end

    for (genvar g = 0; g < NC; g++) begin : g_src
        logic src = 1'b0;
        assign in_clk[g] = src;
        initial begin
            @(negedge clk);
            forever begin
                if (per_cur[g] == 10'd0) begin
                    src = 1'b0;
                    @(negedge clk);
                end else begin
                    src = 1'b1;
                    repeat (int'(per_cur[g]) / 2) @(negedge clk);
                    src = 1'b0;
                    repeat (int'(per_cur[g]) - int'(per_cur[g]) / 2) @(negedge clk);
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic read_ch(input int ch, output int v);
        @(negedge clk);
        rd_sel    = 4'(ch);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        v = int'($signed(rd_value));
    endtask

    function automatic int m_step(input int s);
        return (s == 0) ? 1 : s;
    endfunction

    function automatic int m_ppm(input int p, input bit rs);
        return 1000 - (rs ? 2 * p : 4 * p);
    endfunction

    function automatic int m_val(input int p, input int s, input bit rs);
        int q;
        if (p == 0) return -128;
        q = m_ppm(p, rs) / m_step(s);
        if (q > 127) q = 127;
        if (q < -128) q = -128;
        return q;
    endfunction

    function automatic int m_alarm(input int p, input int s, input int t, input bit e, input bit rs);
        int a;
        if (!e) return 0;
        if (p == 0) return 1;
        a = m_ppm(p, rs);
        if (a < 0) a = -a;
        return (a > (t + 1) * m_step(s)) ? 1 : 0;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int v_rd;
        int p;
        int prev;
        int cur;
        int steps;
        int bad;
        string tag;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: state right after reset
        check("R10 rd_value", int'(rd_value), 0);
        check("R10 hard_alarm", int'(hard_alarm), 0);
        check("R10 disq", int'(disq), 0);
        read_ch(2, v_rd);
        check("R10 stored offset", v_rd, 0);

        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            for (int c = 0; c < NC; c++) per_cur[c] = VECS[v].per[c];
            step_code = VECS[v].stp;
            thr_code  = VECS[v].thr;
            hard_en   = VECS[v].en;
            ref_sel   = VECS[v].rs;
            repeat (4500) @(negedge clk);
            for (int c = 0; c < NC; c++) begin
                p = int'(VECS[v].per[c]);
                read_ch(c, v_rd);
                if (p == 0)                    tag = "R7 value";
                else if (VECS[v].rs)           tag = "R2 value";
                else if (VECS[v].stp == 4'd1)  tag = "R1 value";
                else                           tag = "R3 value";
                check(tag, v_rd, m_val(p, int'(VECS[v].stp), VECS[v].rs));
                tag = VECS[v].en ? "R4 alarm" : "R5 alarm";
                check(tag, int'(hard_alarm[c]),
                      m_alarm(p, int'(VECS[v].stp), int'(VECS[v].thr), VECS[v].en, VECS[v].rs));
                check("R6 disq", int'(disq[c]), int'(hard_alarm[c]));
            end
            if (v == 1) begin
                // R8: selections past the last channel
                read_ch(5, v_rd);
                check("R8 sel 5", v_rd, 0);
                read_ch(15, v_rd);
                check("R8 sel 15", v_rd, 0);
                // R9: latched value survives a select change without a strobe
                read_ch(0, v_rd);
                check("R9 capture", v_rd, 127);
                @(negedge clk);
                rd_sel = 4'd1;
                repeat (3) @(negedge clk);
                check("R9 hold", int'($signed(rd_value)), 127);
            end
        end

        // R11: captures every cycle across a gate update on channel 0
        @(negedge clk);
        per_cur[0] = 10'd246;
        rd_sel     = 4'd0;
        rd_strobe  = 1'b1;
        prev  = 0;
        steps = 0;
        bad   = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            cur = int'($signed(rd_value));
            if (cur < prev || cur > 16) bad = 1;
            if (cur != prev) steps++;
            prev = cur;
        end
        rd_strobe = 1'b0;
        check("R11 values in range and monotone", bad, 0);
        check("R11 at most two changes", (steps <= 2) ? 1 : 0, 1);
        check("R11 final value", prev, 16);
        check("R4 alarm after update", int'(hard_alarm[0]), 1);

        summary();
    end

endmodule